// File: doc/BRIEF.md
# Serial PHY Management Master with Address Scan

This block drives a two-wire serial management bus towards one or more external Ethernet PHYs. It generates the management clock from the system clock, drives the bidirectional data line during the command part of a frame, and releases the line when the PHY is expected to answer or when the bus is idle. The host side uses a request/ready handshake that carries a PHY address, a register address, a write flag and write data. Each completed host transaction returns one response pulse. For reads, the response carries the 16-bit register value.

After reset, the block scans on its own before it accepts any host work. It reads the basic status register (register 1) at PHY addresses 1 through 31 in ascending order. It records each address that answers with a value other than all ones or all zeros, and it stops once its table is full. If any recorded PHY reports, in status bit 6, that it cannot take frames without a preamble, every later transaction starts with a 32-bit preamble. Otherwise the preamble is dropped. The scan itself always sends the preamble.

The block exposes the discovered-PHY table, the number of PHYs found and a primary PHY address. The primary address is the first table entry, or address 1 when nothing was found.

Top module: `mdio_scan_master`

## Requirements
- R1: From reset until the scan finishes, `scan_done` and `req_ready` are low, and a host request held during that time is neither accepted nor answered. Afterwards `scan_done` stays high, and `req_ready` is high whenever no frame is in progress.
- R2: The scan reads register 1 at addresses 1 to 31 in ascending order. It records an address only when the returned value is neither 0xFFFF nor 0x0000. Recorded addresses fill `phy_table` from entry 0 upward (entry i sits at bits 5i+4..5i), unused entries read zero, and `phy_count` gives the number recorded.
- R3: At most MAX_PHYS PHYs are recorded. The scan issues no further read once the table is full.
- R4: `primary_phy` equals table entry 0, or 1 when no PHY was found.
- R5: Every scan frame carries the 32-one preamble. After the scan, `preamble_on` is high exactly when some recorded PHY returned status bit 6 as 0. Host frames carry the preamble only when `preamble_on` is high.
- R6: A read frame drives 14 bits MSB first (01, 10, PHY address, register address). It then releases the line for 19 clock cycles and returns input samples 3 to 18 of that window as data, MSB first. That is 33 MDC cycles, or 65 with the preamble.
- R7: A write frame drives 32 bits MSB first (01, 01, PHY address, register address, 10, data) and then gives 2 released cycles. That is 34 MDC cycles, or 66 with the preamble.
- R8: Each MDC cycle is DIV_HALF system clocks low followed by DIV_HALF high. Line value and output enable change only while MDC is low, and read samples are taken at the end of the low half.
- R9: A read addressed to a PHY that does not answer returns 0xFFFF (the released line reads high).
- R10: Each accepted host request yields exactly one single-cycle `rsp_valid`. `req_ready` is low while a frame runs, and MDC and the output enable are low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write |
| rsp_valid | output | 1 | One-cycle pulse when a host frame completes |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid on reads |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line value when driven |
| mdio_oe | output | 1 | Line output enable |
| mdio_i | input | 1 | Sampled line value |
| scan_done | output | 1 | Scan complete |
| phy_count | output | clog2(MAX_PHYS+1) | Number of PHYs recorded |
| phy_table | output | MAX_PHYS*5 | Recorded PHY addresses |
| primary_phy | output | 5 | First recorded PHY, or 1 |
| preamble_on | output | 1 | Host frames carry the preamble |

## Verification
The bench builds the block with DIV_HALF = 2 and MAX_PHYS = 4. A full 31-address scan with the preamble then costs about 8,000 system clocks, so four separate reset-and-scan populations fit in one run. With four table slots, a six-PHY population reaches the table-full stop early. Measuring frame lengths in MDC edges then shows directly whether the preamble was kept or dropped for both reads and writes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW      = 5;
  localparam int REG_AW      = 5;
  localparam int DW          = 16;
  localparam int PRE_BITS    = 32;
  localparam int RD_CMD_BITS = 14;
  localparam int WR_CMD_BITS = 32;
  localparam int RD_IN_BITS  = 19;
  localparam int WR_IN_BITS  = 2;
  localparam int NOPRE_BIT   = 6;
  localparam logic [REG_AW-1:0] STATUS_REG  = 5'd1;
  localparam logic [PHY_AW-1:0] DEFAULT_PHY = 5'd1;
  localparam logic [PHY_AW-1:0] FIRST_ADDR  = 5'd1;
  localparam logic [PHY_AW-1:0] LAST_ADDR   = 5'd31;

  typedef enum logic [1:0] {ENG_IDLE, ENG_PRE, ENG_OUT, ENG_IN} eng_state_t;
  typedef enum logic [1:0] {SC_ISSUE, SC_WAIT, SC_DONE} scan_state_t;

  // read command, left aligned in a 32-bit shifter
  function automatic logic [31:0] read_cmd(logic [PHY_AW-1:0] phy, logic [REG_AW-1:0] rg);
    return {2'b01, 2'b10, phy, rg, 18'd0};
  endfunction

  function automatic logic [31:0] write_cmd(logic [PHY_AW-1:0] phy, logic [REG_AW-1:0] rg,
                                            logic [DW-1:0] data);
    return {2'b01, 2'b01, phy, rg, 2'b10, data};
  endfunction

  function automatic logic status_present(logic [DW-1:0] s);
    return (s != 16'hFFFF) && (s != 16'h0000);
  endfunction

  function automatic logic status_needs_pre(logic [DW-1:0] s);
    return ~s[NOPRE_BIT];
  endfunction

  // 19 samples, oldest at bit 18: data is samples 2..17
  function automatic logic [DW-1:0] pick_data(logic [RD_IN_BITS-1:0] smp);
    return smp[16:1];
  endfunction
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int DIV_HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV_HALF <= 1) begin : g_direct
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!en || tick)   cnt <= '0;
        else                    cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic              use_pre,
  input  logic [PHY_AW-1:0] phy,
  input  logic [REG_AW-1:0] rg,
  input  logic [DW-1:0]     wdata,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              sample_stb,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  eng_state_t            state;
  logic                  op_wr;
  logic [31:0]           shreg;
  logic [RD_IN_BITS-1:0] smp;
  logic [5:0]            bitcnt;
  logic [5:0]            phase_len;
  logic                  mdc_q;
  logic                  tick;
  logic                  bit_end;

  mdio_tick_gen #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk (clk), .rst_n (rst_n), .en (busy), .tick (tick)
  );

  always_comb begin
    case (state)
      ENG_PRE: phase_len = 6'(PRE_BITS);
      ENG_OUT: phase_len = op_wr ? 6'(WR_CMD_BITS) : 6'(RD_CMD_BITS);
      default: phase_len = op_wr ? 6'(WR_IN_BITS)  : 6'(RD_IN_BITS);
    endcase
  end

  assign busy       = (state != ENG_IDLE);
  assign sample_stb = tick && !mdc_q && (state == ENG_IN);
  assign bit_end    = tick && mdc_q;
  assign mdc        = mdc_q;
  assign mdio_oe    = (state == ENG_PRE) || (state == ENG_OUT);
  assign mdio_o     = (state == ENG_PRE) || ((state == ENG_OUT) && shreg[31]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      op_wr  <= 1'b0;
      shreg  <= '0;
      smp    <= '0;
      bitcnt <= '0;
      mdc_q  <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (state == ENG_IDLE) begin
        if (start) begin
          op_wr  <= is_write;
          shreg  <= is_write ? write_cmd(phy, rg, wdata) : read_cmd(phy, rg);
          state  <= use_pre ? ENG_PRE : ENG_OUT;
          bitcnt <= '0;
          mdc_q  <= 1'b0;
          smp    <= '0;
        end
      end else if (tick) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (state == ENG_IN) smp <= {smp[RD_IN_BITS-2:0], mdio_i};
        end
        if (bit_end) begin
          mdc_q <= 1'b0;
          if (state == ENG_OUT) shreg <= {shreg[30:0], 1'b0};
          if (bitcnt == phase_len - 6'd1) begin
            bitcnt <= '0;
            case (state)
              ENG_PRE: state <= ENG_OUT;
              ENG_OUT: state <= ENG_IN;
              default: begin
                state <= ENG_IDLE;
                done  <= 1'b1;
                if (!op_wr) rdata <= pick_data(smp);
              end
            endcase
          end else begin
            bitcnt <= bitcnt + 6'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_phy_scan.sv
module mdio_phy_scan
  import mdio_pkg::*;
#(
  parameter int MAX_PHYS = 4,
  parameter int CNT_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eng_busy,
  input  logic                       eng_done,
  input  logic [DW-1:0]              eng_rdata,
  output logic                       scan_start,
  output logic [PHY_AW-1:0]          scan_phy,
  output logic                       scan_done,
  output logic [CNT_W-1:0]           found_cnt,
  output logic [MAX_PHYS*PHY_AW-1:0] phy_list,
  output logic                       need_pre
);
  scan_state_t       st;
  logic [PHY_AW-1:0] addr;
  logic              answer;
  logic              record;
  logic              table_full_next;

  assign scan_start      = (st == SC_ISSUE) && !eng_busy;
  assign scan_phy        = addr;
  assign scan_done       = (st == SC_DONE);
  assign answer          = (st == SC_WAIT) && eng_done;
  assign record          = answer && status_present(eng_rdata);
  assign table_full_next = record && (found_cnt == CNT_W'(MAX_PHYS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SC_ISSUE;
      addr      <= FIRST_ADDR;
      found_cnt <= '0;
      need_pre  <= 1'b0;
    end else begin
      case (st)
        SC_ISSUE: if (scan_start) st <= SC_WAIT;
        SC_WAIT: if (answer) begin
          if (record) begin
            found_cnt <= found_cnt + 1'b1;
            if (status_needs_pre(eng_rdata)) need_pre <= 1'b1;
          end
          if (addr == LAST_ADDR || table_full_next) begin
            st <= SC_DONE;
          end else begin
            addr <= addr + 1'b1;
            st   <= SC_ISSUE;
          end
        end
        default: st <= SC_DONE;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_PHYS; g++) begin : g_slot
    logic [PHY_AW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q <= '0;
      else if (record && found_cnt == CNT_W'(g))    slot_q <= addr;
    end
    assign phy_list[g*PHY_AW +: PHY_AW] = slot_q;
  end
endmodule

// File: rtl/mdio_scan_master.sv
module mdio_scan_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 25,
  parameter int MAX_PHYS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [4:0]                   req_phy,
  input  logic [4:0]                   req_reg,
  input  logic [15:0]                  req_wdata,
  output logic                         rsp_valid,
  output logic [15:0]                  rsp_rdata,
  output logic                         mdc,
  output logic                         mdio_o,
  output logic                         mdio_oe,
  input  logic                         mdio_i,
  output logic                         scan_done,
  output logic [$clog2(MAX_PHYS+1)-1:0] phy_count,
  output logic [MAX_PHYS*5-1:0]        phy_table,
  output logic [4:0]                   primary_phy,
  output logic                         preamble_on
);
  localparam int CNT_W = $clog2(MAX_PHYS + 1);

  logic              eng_busy, eng_done, eng_start, eng_wr, eng_pre, sample_stb;
  logic [DW-1:0]     eng_rdata;
  logic [PHY_AW-1:0] eng_phy, scan_phy;
  logic [REG_AW-1:0] eng_reg;
  logic              scan_start, need_pre, host_fire;

  assign req_ready = scan_done && !eng_busy;
  assign host_fire = req_valid && req_ready;

  assign eng_start = scan_done ? host_fire : scan_start;
  assign eng_wr    = scan_done && req_write;
  assign eng_pre   = scan_done ? need_pre : 1'b1;
  assign eng_phy   = scan_done ? req_phy : scan_phy;
  assign eng_reg   = scan_done ? req_reg : STATUS_REG;

  assign rsp_valid   = eng_done && scan_done;
  assign rsp_rdata   = eng_rdata;
  assign preamble_on = need_pre;
  assign primary_phy = (phy_count == '0) ? DEFAULT_PHY : phy_table[PHY_AW-1:0];

  mdio_frame_engine #(.DIV_HALF(DIV_HALF)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (eng_start),
    .is_write   (eng_wr),
    .use_pre    (eng_pre),
    .phy        (eng_phy),
    .rg         (eng_reg),
    .wdata      (req_wdata),
    .mdio_i     (mdio_i),
    .busy       (eng_busy),
    .done       (eng_done),
    .rdata      (eng_rdata),
    .sample_stb (sample_stb),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  mdio_phy_scan #(.MAX_PHYS(MAX_PHYS), .CNT_W(CNT_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .eng_rdata  (eng_rdata),
    .scan_start (scan_start),
    .scan_phy   (scan_phy),
    .scan_done  (scan_done),
    .found_cnt  (phy_count),
    .phy_list   (phy_table),
    .need_pre   (need_pre)
  );
endmodule

// File: rtl/mdio_scan_master_chk.sv
module mdio_scan_master_chk #(
  parameter int DIV_HALF = 25,
  parameter int MAX_PHYS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_ready,
  input logic                          rsp_valid,
  input logic                          mdc,
  input logic                          mdio_o,
  input logic                          mdio_oe,
  input logic                          scan_done,
  input logic [$clog2(MAX_PHYS+1)-1:0] phy_count,
  input logic [4:0]                    primary_phy,
  input logic                          preamble_on,
  input logic                          eng_busy,
  input logic                          sample_stb
);
  int hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= 0;
    else if (mdc) hi_cnt <= hi_cnt + 1;
    else          hi_cnt <= 0;
  end

  p_ready_needs_scan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> scan_done);
  p_scan_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_done);
  p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_count <= ($clog2(MAX_PHYS+1))'(MAX_PHYS));
  p_default_primary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && phy_count == '0) |-> (primary_phy == 5'd1));
  p_pre_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && $past(scan_done)) |-> ($stable(preamble_on) && $stable(phy_count)));
  p_sample_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!mdc && !mdio_oe));
  p_setup_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  p_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  p_high_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= DIV_HALF);
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_host_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> scan_done);
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !req_ready);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_scan_master mdio_scan_master_chk #(.DIV_HALF(DIV_HALF), .MAX_PHYS(MAX_PHYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe),
  .scan_done   (scan_done),
  .phy_count   (phy_count),
  .primary_phy (primary_phy),
  .preamble_on (preamble_on),
  .eng_busy    (eng_busy),
  .sample_stb  (sample_stb)
);

// File: tb/test_mdio_scan_master.sv
module test_mdio_scan_master;
  localparam int DIV = 2;
  localparam int NP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, mdc, mdio_o, mdio_oe, mdio_i, scan_done, preamble_on;
  logic [15:0] rsp_rdata;
  logic [2:0] phy_count;
  logic [NP*5-1:0] phy_table;
  logic [4:0] primary_phy;

  always #2 clk = ~clk;

  mdio_scan_master #(.DIV_HALF(DIV), .MAX_PHYS(NP)) i_mdio_scan_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .scan_done(scan_done), .phy_count(phy_count),
    .phy_table(phy_table), .primary_phy(primary_phy), .preamble_on(preamble_on)
  );

  // PHY population model on the shared line (pulled high when nobody drives)
  logic [31:0] present;
  logic [15:0] regs [32][32];
  logic phy_drive = 1'b0, phy_val = 1'b1;
  int   m_state = 0, m_cnt = 0, edges = 0, n_reads = 0;
  logic [12:0] hdr;
  logic [17:0] wsh;
  logic [4:0]  m_phy, m_reg;
  logic        m_line;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drive ? phy_val : 1'b1);

  always @(posedge mdc) begin
    edges++;
    m_line = mdio_oe ? mdio_o : 1'b1;
    case (m_state)
      0: if (m_line == 1'b0) begin m_state = 1; m_cnt = 0; end
      1: begin
        hdr = {hdr[11:0], m_line};
        m_cnt++;
        if (m_cnt == 13) begin
          m_phy = hdr[9:5];
          m_reg = hdr[4:0];
          m_cnt = 0;
          if (hdr[12] != 1'b1)           m_state = 0;
          else if (hdr[11:10] == 2'b10) begin m_state = 2; n_reads++; end
          else if (hdr[11:10] == 2'b01)  m_state = 3;
          else                           m_state = 0;
        end
      end
      2: begin
        m_cnt++;
        if (m_cnt == 18) begin phy_drive = 1'b0; m_state = 0; end
        else if (present[m_phy]) begin
          phy_drive = 1'b1;
          phy_val   = (m_cnt == 1) ? 1'b0 : regs[m_phy][m_reg][17-m_cnt];
        end
      end
      default: begin
        wsh = {wsh[16:0], m_line};
        m_cnt++;
        if (m_cnt == 18) begin
          if (present[m_phy]) regs[m_phy][m_reg] = wsh[15:0];
          m_state = 0;
        end
      end
    endcase
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, output logic [15:0] q, output int ne);
    int e0;
    int guard;
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_write = wr; req_phy = p; req_reg = r; req_wdata = d;
    e0 = edges;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
    q  = rsp_rdata;
    ne = edges - e0;
    @(negedge clk);
    chk("R10 single response pulse", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic clear_phys();
    present = '0;
    for (int a = 0; a < 32; a++)
      for (int r = 0; r < 32; r++) regs[a][r] = 16'h0000;
  endtask

  // reset, check quiet state, run the scan while a request is held off
  task automatic run_scan(input int exp_reads, input int exp_edges);
    int guard;
    bit leaked;
    rst_n = 1'b0;
    m_state = 0; phy_drive = 1'b0;
    repeat (4) @(negedge clk);
    edges = 0; n_reads = 0;
    chk("R1 reset ready low", {31'd0, req_ready}, 32'd0);
    chk("R1 reset scan_done low", {31'd0, scan_done}, 32'd0);
    chk("R10 reset line idle", {30'd0, mdc, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd3; req_reg = 5'd0; req_wdata = 16'hDEAD;
    leaked = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_ready || rsp_valid || scan_done) leaked = 1'b1;
    end
    req_valid = 1'b0;
    chk("R1 request refused during scan", {31'd0, leaked}, 32'd0);
    guard = 0;
    while (!scan_done && guard < 40000) begin @(negedge clk); guard++; end
    chk("R1 scan completes", {31'd0, scan_done}, 32'd1);
    chk("R1 ready after scan", {31'd0, req_ready}, 32'd1);
    chk("R3 scan read count", exp_reads, n_reads);
    chk("R5 scan frames carry preamble", edges, exp_edges);
  endtask

  // host vector: {wr, phy, reg, wdata, expected rdata, expected mdc edges}
  localparam logic [49:0] VEC [10] = '{
    {1'b1, 5'd2,  5'd0,  16'h1234, 16'h0000, 7'd34},
    {1'b0, 5'd2,  5'd0,  16'h0000, 16'h1234, 7'd33},
    {1'b1, 5'd4,  5'd31, 16'hFFFF, 16'h0000, 7'd34},
    {1'b0, 5'd4,  5'd31, 16'h0000, 16'hFFFF, 7'd33},
    {1'b1, 5'd8,  5'd5,  16'h0001, 16'h0000, 7'd34},
    {1'b0, 5'd8,  5'd5,  16'h0000, 16'h0001, 7'd33},
    {1'b0, 5'd6,  5'd1,  16'h0000, 16'h7869, 7'd33},
    {1'b0, 5'd30, 5'd2,  16'h0000, 16'hFFFF, 7'd33},
    {1'b1, 5'd10, 5'd16, 16'hA5C3, 16'h0000, 7'd34},
    {1'b0, 5'd10, 5'd16, 16'h0000, 16'hA5C3, 7'd33}
  };

  logic [15:0] q;
  int ne;

  initial begin
    // Scenario B: six PHYs all accept suppressed preamble; table fills at 4
    clear_phys();
    for (int a = 2; a <= 12; a += 2) begin present[a] = 1'b1; regs[a][1] = 16'h7869; end
    run_scan(8, 8 * 65);
    chk("R2/R3 count full", {29'd0, phy_count}, 32'd4);
    chk("R2 table order", {12'd0, phy_table}, {12'd0, 5'd8, 5'd6, 5'd4, 5'd2});
    chk("R4 primary first", {27'd0, primary_phy}, 32'd2);
    chk("R5 preamble dropped", {31'd0, preamble_on}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      host_op(VEC[i][49], VEC[i][48:44], VEC[i][43:39], VEC[i][38:23], q, ne);
      if (VEC[i][49]) chk("R7 write frame length", ne, {25'd0, VEC[i][6:0]});
      else begin
        chk("R6/R9 read data", {16'd0, q}, {16'd0, VEC[i][22:7]});
        chk("R6 read frame length", ne, {25'd0, VEC[i][6:0]});
      end
    end

    // Scenario A: one PHY needs preamble, one answers zero
    clear_phys();
    present[3] = 1'b1;  regs[3][1]  = 16'h7849;
    present[5] = 1'b1;  regs[5][1]  = 16'h0000;
    present[9] = 1'b1;  regs[9][1]  = 16'h7809;
    present[20] = 1'b1; regs[20][1] = 16'h786D;
    run_scan(31, 31 * 65);
    chk("R2 count skips zero status", {29'd0, phy_count}, 32'd3);
    chk("R2 table with empty slot", {12'd0, phy_table}, {12'd0, 5'd0, 5'd20, 5'd9, 5'd3});
    chk("R4 primary", {27'd0, primary_phy}, 32'd3);
    chk("R5 preamble kept", {31'd0, preamble_on}, 32'd1);
    host_op(1'b0, 5'd9, 5'd1, 16'h0, q, ne);
    chk("R6 read with preamble data", {16'd0, q}, 32'h7809);
    chk("R5 read with preamble length", ne, 65);
    host_op(1'b1, 5'd20, 5'd4, 16'h01E1, q, ne);
    chk("R7 write with preamble length", ne, 66);
    host_op(1'b0, 5'd20, 5'd4, 16'h0, q, ne);
    chk("R7 write landed", {16'd0, q}, 32'h01E1);

    // Scenario C: nothing on the bus
    clear_phys();
    run_scan(31, 31 * 65);
    chk("R2 none found", {29'd0, phy_count}, 32'd0);
    chk("R4 default primary", {27'd0, primary_phy}, 32'd1);
    chk("R5 no preamble when empty", {31'd0, preamble_on}, 32'd0);
    host_op(1'b0, 5'd7, 5'd0, 16'h0, q, ne);
    chk("R9 absent PHY reads ones", {16'd0, q}, 32'hFFFF);

    // Scenario D: only the last address
    clear_phys();
    present[31] = 1'b1; regs[31][1] = 16'h7849;
    run_scan(31, 31 * 65);
    chk("R2 last address found", {29'd0, phy_count}, 32'd1);
    chk("R4 primary last address", {27'd0, primary_phy}, 32'd31);
    chk("R2 unused slots zero", {12'd0, phy_table}, 32'd31);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule